// File: doc/BRIEF.md
# Predicated Vector Add/Subtract Sequencer with Condition-Code Gated Write-Back

This block walks an integer add or subtract across a run of consecutive registers, one element per clock. A start pulse loads the vector length, a per-element enable mask, three register base indices (two operands and a destination), a base slot in a small condition-code array, a record flag, a three-bit test field and the operation select. For each element that the mask enables, the block reads two operands through combinational read ports. It forms the 64-bit result and classifies it as negative, positive or zero.

The classification serves two purposes. When the record flag is set, the three-bit code goes to the condition-code array for every enabled element. The code is also tested against the three-bit test field: the field picks one code bit and gives the value that bit must have. The result reaches the destination register only when the test passes, so the test acts as a second, data-dependent mask on top of the static one. Writes go out through a single combinational write port in the same cycle as the reads. A later element therefore sees what an earlier element of the same run wrote.

Top module: `pred_vec_cr`

## Requirements
- R1: After reset, busy, done, rf_we and cr_we are 0. A start pulse while idle loads the configuration, with the length clamped to MAXVL. busy is then 1 for exactly vl cycles, starting the cycle after start. A start pulse while busy has no effect on the run.
- R2: In the k-th busy cycle (k from 0), ra_addr = (ra + k) mod 2^RIW and rb_addr = (rb + k) mod 2^RIW.
- R3: An element whose pred_mask bit is 0 produces neither rf_we nor cr_we in its cycle.
- R4: The result is ra_data + rb_data when op_sub is 0 and ra_data - rb_data when op_sub is 1, both modulo 2^64.
- R5: The condition code puts the result's sign-is-negative flag in bit 0 and strictly-positive in bit 1, with the result treated as signed 64-bit. Bit 2 marks a result of zero. Exactly one bit is set.
- R6: With rec_cc = 1, each enabled element drives cr_we with cr_waddr = (cc_base + k) mod 2^CIW and cr_wdata = its code, whether or not the result is stored.
- R7: With rec_cc = 0, cr_we stays 0 for the whole run.
- R8: Let sel = cond_test[1:0] pick code bit sel, where sel = 3 picks a constant 0. Let cond_test[2] be the required value. An enabled element writes its result to rf_waddr = (rt + k) mod 2^RIW exactly when the picked bit equals the required value.
- R9: done is a one-cycle pulse in the cycle after the last busy cycle. With vl = 0 it comes in the cycle after start, with no writes.
- R10: Elements are processed in ascending order, and a register written by element k is seen by the reads of every later element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while idle |
| vl | input | VLW | Element count, clamped to MAXVL |
| pred_mask | input | MAXVL | Per-element enable, bit k for element k |
| ra | input | RIW | First operand base register |
| rb | input | RIW | Second operand base register |
| rt | input | RIW | Destination base register |
| cc_base | input | CIW | Base slot in the condition-code array |
| rec_cc | input | 1 | Record condition codes |
| cond_test | input | 3 | [1:0] code bit select, [2] required value |
| op_sub | input | 1 | 0 add, 1 subtract |
| ra_addr | output | RIW | First operand read address |
| ra_data | input | XLEN | First operand read data (combinational) |
| rb_addr | output | RIW | Second operand read address |
| rb_data | input | XLEN | Second operand read data (combinational) |
| rf_we | output | 1 | Result write enable |
| rf_waddr | output | RIW | Result write address |
| rf_wdata | output | XLEN | Result write data |
| cr_we | output | 1 | Condition-code write enable |
| cr_waddr | output | CIW | Condition-code write slot |
| cr_wdata | output | 3 | Condition code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A stale element counter or configuration register shows up in the very next busy cycle. It appears as a read address that fails to step by one, or as a write landing at a wrong destination or slot. A wrong classification or a wrong test select does not stay in the block. It leaves a register holding a result it should not hold, or missing one it should, and later elements of the same run can carry the error forward through chained reads. Comparing the whole register file, the condition-code array and the write counts after each run catches such faults when the run ends. A wrong end-of-run count shifts the done pulse by at least one cycle.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // bit 0 negative, bit 1 positive, bit 2 zero
    typedef struct packed {
        logic zero;
        logic pos;
        logic neg;
    } cc_t;

    typedef struct packed {
        logic [2:0] test;
        logic       rec;
        logic       sub;
    } run_ctl_t;

    function automatic cc_t cc_classify(input logic is_neg, input logic is_zero);
        cc_t c;
        c.neg  = is_neg;
        c.pos  = !is_neg && !is_zero;
        c.zero = is_zero;
        return c;
    endfunction

    function automatic logic cc_pick(input cc_t c, input logic [1:0] sel);
        logic b;
        case (sel)
            2'd0:    b = c.neg;
            2'd1:    b = c.pos;
            2'd2:    b = c.zero;
            default: b = 1'b0;
        endcase
        return b;
    endfunction

    function automatic logic cc_pass(input cc_t c, input logic [2:0] test);
        return cc_pick(c, test[1:0]) == test[2];
    endfunction

endpackage

// File: rtl/pvc_seq.sv
module pvc_seq
    import pvc_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int VLW   = 5,
    parameter int RIW   = 5,
    parameter int CIW   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic [MAXVL-1:0] pred_mask,
    input  logic [RIW-1:0]   ra,
    input  logic [RIW-1:0]   rb,
    input  logic [RIW-1:0]   rt,
    input  logic [CIW-1:0]   cc_base,
    input  run_ctl_t         ctl_in,
    output logic             busy,
    output logic             done,
    output logic             elem_act,
    output logic [RIW-1:0]   ra_idx,
    output logic [RIW-1:0]   rb_idx,
    output logic [RIW-1:0]   rt_idx,
    output logic [CIW-1:0]   cr_idx,
    output run_ctl_t         ctl
);
    localparam int MIW = (MAXVL > 1) ? $clog2(MAXVL) : 1;
    localparam logic [VLW-1:0] VL_CAP = VLW'(MAXVL);

    seq_state_e       state;
    logic [VLW-1:0]   idx;
    logic [VLW-1:0]   len_q;
    logic [MAXVL-1:0] mask_q;
    logic [RIW-1:0]   ra_q, rb_q, rt_q;
    logic [CIW-1:0]   cb_q;
    logic [VLW-1:0]   vl_clamped;
    logic             last;
    logic [MIW-1:0]   bit_sel;

    assign vl_clamped = (vl > VL_CAP) ? VL_CAP : vl;
    assign last       = (idx == len_q - VLW'(1));
    assign bit_sel    = MIW'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            idx    <= '0;
            len_q  <= '0;
            mask_q <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            rt_q   <= '0;
            cb_q   <= '0;
            ctl    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        idx    <= '0;
                        len_q  <= vl_clamped;
                        mask_q <= pred_mask;
                        ra_q   <= ra;
                        rb_q   <= rb;
                        rt_q   <= rt;
                        cb_q   <= cc_base;
                        ctl    <= ctl_in;
                        if (vl_clamped == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= SEQ_RUN;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (last) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + VLW'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state == SEQ_RUN);
    assign elem_act = busy && mask_q[bit_sel];
    assign ra_idx   = ra_q + RIW'(idx);
    assign rb_idx   = rb_q + RIW'(idx);
    assign rt_idx   = rt_q + RIW'(idx);
    assign cr_idx   = cb_q + CIW'(idx);

endmodule

// File: rtl/pvc_lane.sv
module pvc_lane
    import pvc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            sub,
    output logic [XLEN-1:0] res,
    output cc_t             cc
);
    logic [XLEN-1:0] opb_eff;
    logic            cin;

    // subtract as a + ~b + 1 so one adder serves both operations
    assign opb_eff = sub ? ~opb : opb;
    assign cin     = sub;
    assign res     = opa + opb_eff + XLEN'(cin);
    assign cc      = cc_classify(res[XLEN-1], res == '0);

endmodule

// File: rtl/pvc_gate.sv
module pvc_gate
    import pvc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int RIW  = 5,
    parameter int CIW  = 4
) (
    input  logic            act,
    input  logic            rec,
    input  logic [2:0]      test,
    input  logic [XLEN-1:0] res,
    input  cc_t             cc,
    input  logic [RIW-1:0]  rt_idx,
    input  logic [CIW-1:0]  cr_idx,
    output logic            rf_we,
    output logic [RIW-1:0]  rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            cr_we,
    output logic [CIW-1:0]  cr_waddr,
    output logic [2:0]      cr_wdata
);
    logic pass;

    assign pass     = cc_pass(cc, test);
    assign rf_we    = act && pass;
    assign rf_waddr = rt_idx;
    assign rf_wdata = res;
    assign cr_we    = act && rec;
    assign cr_waddr = cr_idx;
    assign cr_wdata = cc;

endmodule

// File: rtl/pred_vec_cr.sv
module pred_vec_cr
    import pvc_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int MAXVL = 16,
    parameter int RIW   = 5,
    parameter int CIW   = 4,
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic [MAXVL-1:0] pred_mask,
    input  logic [RIW-1:0]   ra,
    input  logic [RIW-1:0]   rb,
    input  logic [RIW-1:0]   rt,
    input  logic [CIW-1:0]   cc_base,
    input  logic             rec_cc,
    input  logic [2:0]       cond_test,
    input  logic             op_sub,
    output logic [RIW-1:0]   ra_addr,
    input  logic [XLEN-1:0]  ra_data,
    output logic [RIW-1:0]   rb_addr,
    input  logic [XLEN-1:0]  rb_data,
    output logic             rf_we,
    output logic [RIW-1:0]   rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             cr_we,
    output logic [CIW-1:0]   cr_waddr,
    output logic [2:0]       cr_wdata,
    output logic             busy,
    output logic             done
);
    run_ctl_t        ctl_in, ctl;
    logic            act;
    logic [RIW-1:0]  rt_idx;
    logic [CIW-1:0]  cr_idx;
    logic [XLEN-1:0] res;
    cc_t             cc;

    assign ctl_in = '{test: cond_test, rec: rec_cc, sub: op_sub};

    pvc_seq #(.MAXVL(MAXVL), .VLW(VLW), .RIW(RIW), .CIW(CIW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .pred_mask(pred_mask),
        .ra(ra), .rb(rb), .rt(rt), .cc_base(cc_base), .ctl_in(ctl_in),
        .busy(busy), .done(done), .elem_act(act),
        .ra_idx(ra_addr), .rb_idx(rb_addr), .rt_idx(rt_idx), .cr_idx(cr_idx),
        .ctl(ctl)
    );

    pvc_lane #(.XLEN(XLEN)) u_lane (
        .opa(ra_data), .opb(rb_data), .sub(ctl.sub), .res(res), .cc(cc)
    );

    pvc_gate #(.XLEN(XLEN), .RIW(RIW), .CIW(CIW)) u_gate (
        .act(act), .rec(ctl.rec), .test(ctl.test), .res(res), .cc(cc),
        .rt_idx(rt_idx), .cr_idx(cr_idx),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .cr_we(cr_we), .cr_waddr(cr_waddr), .cr_wdata(cr_wdata)
    );

endmodule

// File: rtl/pvc_chk.sv
module pvc_chk #(
    parameter int RIW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           rec_cc,
    input logic [2:0]     cond_test,
    input logic           busy,
    input logic           done,
    input logic [RIW-1:0] ra_addr,
    input logic [RIW-1:0] rb_addr,
    input logic           rf_we,
    input logic           cr_we,
    input logic [2:0]     cr_wdata
);
    logic       seen_rec;
    logic [2:0] seen_test;
    logic       picked;
    logic       test_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rec  <= 1'b0;
            seen_test <= 3'b0;
        end else if (start && !busy) begin
            seen_rec  <= rec_cc;
            seen_test <= cond_test;
        end
    end

    always_comb begin
        case (seen_test[1:0])
            2'd0:    picked = cr_wdata[0];
            2'd1:    picked = cr_wdata[1];
            2'd2:    picked = cr_wdata[2];
            default: picked = 1'b0;
        endcase
        test_ok = (picked == seen_test[2]);
    end

    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> $countones(cr_wdata) == 1); // R5
    AST_CR_NEEDS_REC: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> seen_rec); // R7
    AST_WR_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        (rf_we || cr_we) |-> busy); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_PASS_WRITES: assert property (@(posedge clk) disable iff (rst)
        (cr_we && test_ok) |-> rf_we); // R8
    AST_FAIL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cr_we && !test_ok) |-> !rf_we); // R8
    AST_RA_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ra_addr == RIW'($past(ra_addr) + 1'b1)); // R2
    AST_RB_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> rb_addr == RIW'($past(rb_addr) + 1'b1)); // R2

endmodule

bind pred_vec_cr pvc_chk #(.RIW(RIW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .rec_cc(rec_cc), .cond_test(cond_test),
    .busy(busy), .done(done), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .rf_we(rf_we), .cr_we(cr_we), .cr_wdata(cr_wdata)
);

// File: tb/sim_pred_vec_cr.sv
`timescale 1ns/1ps
module sim_pred_vec_cr;
    localparam int XLEN  = 64;
    localparam int MAXVL = 16;
    localparam int RIW   = 5;
    localparam int CIW   = 4;
    localparam int VLW   = $clog2(MAXVL + 1);
    localparam int NREG  = 1 << RIW;
    localparam int NCR   = 1 << CIW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [VLW-1:0]   vl = '0;
    logic [MAXVL-1:0] pred_mask = '0;
    logic [RIW-1:0]   ra = '0, rb = '0, rt = '0;
    logic [CIW-1:0]   cc_base = '0;
    logic             rec_cc = 1'b0;
    logic [2:0]       cond_test = 3'b0;
    logic             op_sub = 1'b0;
    logic [RIW-1:0]   ra_addr, rb_addr, rf_waddr;
    logic [XLEN-1:0]  ra_data, rb_data, rf_wdata;
    logic             rf_we, cr_we, busy, done;
    logic [CIW-1:0]   cr_waddr;
    logic [2:0]       cr_wdata;

    logic [XLEN-1:0] rf [NREG];
    logic [2:0]      cr [NCR];
    logic [XLEN-1:0] exp_rf [NREG];
    logic [2:0]      exp_cr [NCR];
    int rf_wr_cnt = 0, cr_wr_cnt = 0;
    int exp_rfw, exp_crw;
    int checks = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign ra_data = rf[ra_addr];
    assign rb_data = rf[rb_addr];

    always @(posedge clk) begin
        if (rf_we) begin rf[rf_waddr] <= rf_wdata; rf_wr_cnt <= rf_wr_cnt + 1; end
        if (cr_we) begin cr[cr_waddr] <= cr_wdata; cr_wr_cnt <= cr_wr_cnt + 1; end
    end

    pred_vec_cr #(.XLEN(XLEN), .MAXVL(MAXVL), .RIW(RIW), .CIW(CIW)) u0 (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .pred_mask(pred_mask),
        .ra(ra), .rb(rb), .rt(rt), .cc_base(cc_base), .rec_cc(rec_cc),
        .cond_test(cond_test), .op_sub(op_sub),
        .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .cr_we(cr_we), .cr_waddr(cr_waddr), .cr_wdata(cr_wdata),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_cc(input logic [63:0] r);
        if ($signed(r) < 0) return 3'b001;
        if (r == 64'd0)     return 3'b100;
        return 3'b010;
    endfunction

    function automatic bit ref_pass(input logic [2:0] c, input logic [2:0] t);
        logic b;
        b = (t[1:0] == 2'd3) ? 1'b0 : c[t[1:0]];
        return b == t[2];
    endfunction

    task automatic model(input int n, input logic [MAXVL-1:0] m, input int a, input int b,
                         input int d, input int cb, input bit rc, input logic [2:0] t, input bit s);
        exp_rfw = 0; exp_crw = 0;
        for (int k = 0; k < n; k++) begin
            if (m[k]) begin
                logic [63:0] x, y, r;
                logic [2:0]  c;
                x = exp_rf[(a + k) % NREG];
                y = exp_rf[(b + k) % NREG];
                r = s ? x - y : x + y;
                c = ref_cc(r);
                if (rc) begin exp_cr[(cb + k) % NCR] = c; exp_crw++; end
                if (ref_pass(c, t)) begin exp_rf[(d + k) % NREG] = r; exp_rfw++; end
            end
        end
    endtask

    task automatic run_op(input int n, input logic [MAXVL-1:0] m, input int a, input int b,
                          input int d, input int cb, input bit rc, input logic [2:0] t,
                          input bit s, input bit poke);
        int cyc, rfw0, crw0, nm, eff;
        bit ok;
        eff = (n > MAXVL) ? MAXVL : n;
        for (int i = 0; i < NREG; i++) exp_rf[i] = rf[i];
        for (int i = 0; i < NCR; i++)  exp_cr[i] = cr[i];
        model(eff, m, a, b, d, cb, rc, t, s);
        rfw0 = rf_wr_cnt; crw0 = cr_wr_cnt;
        vl = VLW'(n); pred_mask = m; ra = RIW'(a); rb = RIW'(b); rt = RIW'(d);
        cc_base = CIW'(cb); rec_cc = rc; cond_test = t; op_sub = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (eff > 0) begin
            chk(busy == 1'b1, "R1 busy after start", 64'(busy), 64'd1);
            chk(ra_addr == RIW'(a) && rb_addr == RIW'(b), "R2 first addresses",
                {32'(ra_addr), 32'(rb_addr)}, {32'(RIW'(a)), 32'(RIW'(b))});
        end
        while (!done && cyc < 100) begin
            if (poke && cyc == 1) begin
                // R1: a second start mid-run with a different setup must be ignored
                vl = VLW'(1); ra = ~ra; rt = ~rt; rec_cc = ~rec_cc; cond_test = 3'b000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == eff + 1, "R9 R1 done latency", 64'(cyc), 64'(eff + 1));
        @(negedge clk);
        chk(!done && !busy, "R9 done single cycle", 64'({done, busy}), 64'd0);
        ok = 1; nm = 0;
        for (int i = 0; i < NREG; i++) if (rf[i] !== exp_rf[i]) begin ok = 0; nm = i; end
        chk(ok, "R4 R8 R10 register contents", rf[nm], exp_rf[nm]);
        ok = 1; nm = 0;
        for (int i = 0; i < NCR; i++) if (cr[i] !== exp_cr[i]) begin ok = 0; nm = i; end
        chk(ok, "R5 R6 R7 code array contents", 64'(cr[nm]), 64'(exp_cr[nm]));
        chk(rf_wr_cnt - rfw0 == exp_rfw, "R3 R8 result write count", 64'(rf_wr_cnt - rfw0), 64'(exp_rfw));
        chk(cr_wr_cnt - crw0 == exp_crw, "R3 R7 code write count", 64'(cr_wr_cnt - crw0), 64'(exp_crw));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7031);
        for (int i = 0; i < NREG; i++) rf[i] = {$urandom, $urandom};
        rf[3] = 64'd5; rf[4] = 64'd5; rf[5] = 64'd9;
        for (int i = 0; i < NCR; i++) cr[i] = 3'b111;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !rf_we && !cr_we, "R1 reset state",
            64'({busy, done, rf_we, cr_we}), 64'd0);

        // R5 R8: zero result, test on zero bit, require set
        run_op(1, 16'h0001, 3, 4, 20, 0, 1, 3'b110, 1, 0);
        // R8: select 3 with required 1 never writes; R6: codes still recorded
        run_op(8, 16'h00ff, 0, 8, 16, 2, 1, 3'b111, 0, 0);
        // R8: select 3 with required 0 always writes; R7: no codes
        run_op(8, 16'h00ff, 0, 8, 16, 2, 0, 3'b011, 1, 0);
        // R3: empty mask
        run_op(MAXVL, 16'h0000, 1, 2, 3, 4, 1, 3'b011, 0, 0);
        // R9: zero length
        run_op(0, 16'hffff, 1, 2, 3, 4, 1, 3'b011, 0, 0);
        // R10: chained destination overlaps next source
        run_op(MAXVL, 16'hffff, 5, 5, 6, 0, 1, 3'b011, 0, 0);
        // R2 R6: wrap of register and slot indices
        run_op(MAXVL, 16'hb5ad, 28, 30, 25, 12, 1, 3'b000, 1, 0);
        // R1: start while busy ignored
        run_op(10, 16'h03ff, 2, 9, 18, 5, 1, 3'b101, 1, 1);
        // R1: over-long length clamped
        run_op(MAXVL + 1, 16'hffff, 0, 1, 2, 3, 1, 3'b010, 0, 0);

        for (int it = 0; it < 120; it++) begin
            if (it % 16 == 0) for (int i = 0; i < NREG; i++)
                rf[i] = ($urandom % 4 == 0) ? 64'($urandom % 3) : {$urandom, $urandom};
            run_op($urandom % (MAXVL + 1), MAXVL'($urandom), $urandom % NREG, $urandom % NREG,
                   $urandom % NREG, $urandom % NCR, 1'($urandom), 3'($urandom), 1'($urandom),
                   ($urandom % 8) == 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule